// File: doc/BRIEF.md
# Intra-Group Store-Load Overlap Detector

This block guards one dispatch group against a load that reads bytes an earlier store of the same group is still writing. It records the footprint of each store committed during the group. A footprint is a base identifier, a signed byte offset from that base, and an access size in bytes. Each cycle it compares the load presented on the query port against every recorded footprint. If the bytes overlap, it raises a single flag, and the issue logic answers the flag by inserting a noop.

The table holds four entries, and a group-end pulse empties it. Only footprints that share a base identifier are compared. Offsets are two's-complement values, and each end address is formed one bit wider than the offset so that it never wraps. The block always accepts input and applies no back-pressure: a store commit strobe that arrives while the table is full is dropped silently, and a query is answered in the same cycle it is presented.

Top module: `sld_overlap_detector`

## Requirements
- R1: After reset the table is empty, so every query returns overlap = 0 until a store has been recorded.
- R2: A store recorded in the table becomes visible to queries from the cycle after its commit strobe. A query with the same base and the same offset as a recorded store always hits, even if either size is zero.
- R3: With equal bases and a store offset below the load offset, the query hits exactly when store offset + store size > load offset.
- R4: With equal bases and a store offset not below the load offset, the query hits exactly when load offset + load size > store offset.
- R5: A recorded store whose base identifier differs from the load's base never causes a hit.
- R6: At most four stores are recorded per group. A fifth or later commit strobe in the same group is dropped, and a load that overlaps only the dropped store returns overlap = 0.
- R7: A group-end pulse invalidates every entry. Queries in the following cycle return 0 for every footprint recorded before the pulse.
- R8: When a commit strobe and a group-end pulse arrive in the same cycle, the clear wins and the table is left empty.
- R9: overlap is driven combinationally in the cycle the query is presented, and it is 0 whenever ld_valid is 0.
- R10: Offsets are 32-bit signed values and end addresses are computed without wrap. For example, a store at 0x7FFFFFFF of size 15 does not overlap a load at 0x80000000 (which is negative) of size 15. It does overlap a load at 0x7FFFFFF1 of size 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_commit | input | 1 | Store commit strobe |
| st_base | input | 8 | Store base identifier |
| st_ofs | input | 32 | Store offset, signed |
| st_size | input | 4 | Store size in bytes |
| ld_valid | input | 1 | Load query present |
| ld_base | input | 8 | Load base identifier |
| ld_ofs | input | 32 | Load offset, signed |
| ld_size | input | 4 | Load size in bytes |
| grp_end | input | 1 | Dispatch group end, clears the table |
| overlap | output | 1 | Load overlaps a recorded store |

## Verification
The bench builds the block with its default parameters: four entries, 8-bit bases, 32-bit offsets and 4-bit sizes. With four entries, a short burst of stores fills the table and reaches the dropped-fifth-store case. With 32-bit offsets, the signed extremes near 0x7FFFFFFF and 0x80000000 can be reached directly, which exposes any comparison that wraps. The random phase draws bases from a pool of three and offsets from a narrow window, so equal-base footprints that straddle each other occur often.

// File: rtl/sld_pkg.sv
package sld_pkg;
  typedef enum logic [1:0] {
    TBL_HOLD  = 2'd0,
    TBL_PUSH  = 2'd1,
    TBL_CLEAR = 2'd2
  } tbl_op_e;
endpackage

// File: rtl/sld_overlap_cmp.sv
module sld_overlap_cmp #(
  parameter int unsigned BASE_W = 8,
  parameter int unsigned OFS_W  = 32,
  parameter int unsigned SIZE_W = 4
) (
  input  logic [BASE_W-1:0] e_base,
  input  logic [OFS_W-1:0]  e_ofs,
  input  logic [SIZE_W-1:0] e_size,
  input  logic [BASE_W-1:0] q_base,
  input  logic [OFS_W-1:0]  q_ofs,
  input  logic [SIZE_W-1:0] q_size,
  output logic              hit
);
  localparam int unsigned XW = OFS_W + 1;

  logic signed [XW-1:0] e_lo, e_hi, q_lo, q_hi;
  logic base_eq, exact, below, spans;

  always_comb begin
    e_lo    = $signed({e_ofs[OFS_W-1], e_ofs});
    q_lo    = $signed({q_ofs[OFS_W-1], q_ofs});
    e_hi    = e_lo + $signed(XW'(e_size));
    q_hi    = q_lo + $signed(XW'(q_size));
    base_eq = (e_base == q_base);
    exact   = (e_ofs == q_ofs);
    below   = (e_lo < q_lo);
    spans   = below ? (e_hi > q_lo) : (q_hi > e_lo);
    hit     = base_eq && (exact || spans);
  end

  // R5: different bases must never compare as a hit
  always_comb begin
    if (!base_eq) a_r5_base_gate : assert (!hit);
  end
endmodule

// File: rtl/sld_fp_table.sv
module sld_fp_table
  import sld_pkg::*;
#(
  parameter int unsigned NUM    = 4,
  parameter int unsigned BASE_W = 8,
  parameter int unsigned OFS_W  = 32,
  parameter int unsigned SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tbl_op_e           op,
  input  logic [BASE_W-1:0] w_base,
  input  logic [OFS_W-1:0]  w_ofs,
  input  logic [SIZE_W-1:0] w_size,
  output logic [NUM-1:0]    ent_valid,
  output logic [BASE_W-1:0] ent_base [NUM],
  output logic [OFS_W-1:0]  ent_ofs  [NUM],
  output logic [SIZE_W-1:0] ent_size [NUM]
);
  localparam int unsigned CNT_W = $clog2(NUM + 1);

  logic [CNT_W-1:0] fill;
  logic             room;

  assign room = (fill < CNT_W'(NUM));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= '0;
    end else if (op == TBL_CLEAR) begin
      fill <= '0;
    end else if (op == TBL_PUSH && room) begin
      fill <= fill + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[i] <= 1'b0;
        ent_base[i]  <= '0;
        ent_ofs[i]   <= '0;
        ent_size[i]  <= '0;
      end else if (op == TBL_CLEAR) begin
        ent_valid[i] <= 1'b0;
      end else if (op == TBL_PUSH && room && fill == CNT_W'(i)) begin
        ent_valid[i] <= 1'b1;
        ent_base[i]  <= w_base;
        ent_ofs[i]   <= w_ofs;
        ent_size[i]  <= w_size;
      end
    end
  end

  // R6: never more valid entries than slots, and the fill count agrees
  a_r6_fill_matches : assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ent_valid) == int'(fill));
  // R6: a full table stays unchanged under further pushes
  a_r6_full_holds : assert property (@(posedge clk) disable iff (!rst_n)
    (!room && op == TBL_PUSH) |=> $stable(ent_valid) && $stable(fill));
  // R7 / R8: a clear leaves nothing valid, whatever else arrived
  a_r7_clear_empties : assert property (@(posedge clk) disable iff (!rst_n)
    (op == TBL_CLEAR) |=> (ent_valid == '0));
endmodule

// File: rtl/sld_overlap_detector.sv
module sld_overlap_detector
  import sld_pkg::*;
#(
  parameter int unsigned NUM    = 4,
  parameter int unsigned BASE_W = 8,
  parameter int unsigned OFS_W  = 32,
  parameter int unsigned SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_commit,
  input  logic [BASE_W-1:0] st_base,
  input  logic [OFS_W-1:0]  st_ofs,
  input  logic [SIZE_W-1:0] st_size,
  input  logic              ld_valid,
  input  logic [BASE_W-1:0] ld_base,
  input  logic [OFS_W-1:0]  ld_ofs,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic              grp_end,
  output logic              overlap
);
  tbl_op_e           op;
  logic [NUM-1:0]    ent_valid;
  logic [BASE_W-1:0] ent_base [NUM];
  logic [OFS_W-1:0]  ent_ofs  [NUM];
  logic [SIZE_W-1:0] ent_size [NUM];
  logic [NUM-1:0]    raw_hit;
  logic              any_base;

  always_comb begin
    if (grp_end)        op = TBL_CLEAR;
    else if (st_commit) op = TBL_PUSH;
    else                op = TBL_HOLD;
  end

  sld_fp_table #(
    .NUM(NUM), .BASE_W(BASE_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .op(op),
    .w_base(st_base), .w_ofs(st_ofs), .w_size(st_size),
    .ent_valid(ent_valid), .ent_base(ent_base),
    .ent_ofs(ent_ofs), .ent_size(ent_size)
  );

  for (genvar i = 0; i < NUM; i++) begin : g_cmp
    sld_overlap_cmp #(
      .BASE_W(BASE_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W)
    ) u_cmp (
      .e_base(ent_base[i]), .e_ofs(ent_ofs[i]), .e_size(ent_size[i]),
      .q_base(ld_base), .q_ofs(ld_ofs), .q_size(ld_size),
      .hit(raw_hit[i])
    );
  end

  assign overlap = ld_valid && |(raw_hit & ent_valid);

  always_comb begin
    any_base = 1'b0;
    for (int i = 0; i < NUM; i++)
      if (ent_valid[i] && ent_base[i] == ld_base) any_base = 1'b1;
  end

  // R9: no query, no flag
  a_r9_idle_low : assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> !overlap);
  // R5: no recorded store with the load's base gives no flag
  a_r5_no_base_no_hit : assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !any_base) |-> !overlap);
  // R2: exact match on the first slot always flags
  a_r2_exact_slot0 : assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ent_valid[0] && ent_base[0] == ld_base && ent_ofs[0] == ld_ofs)
      |-> overlap);
  // R7: the cycle after a group end nothing can flag
  a_r7_after_clear : assert property (@(posedge clk) disable iff (!rst_n)
    grp_end |=> !overlap);
endmodule

// File: tb/sld_overlap_detector_tb_top.sv
`timescale 1ns/1ps
module sld_overlap_detector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_commit = 1'b0;
  logic [7:0]  st_base = '0;
  logic [31:0] st_ofs = '0;
  logic [3:0]  st_size = '0;
  logic        ld_valid = 1'b0;
  logic [7:0]  ld_base = '0;
  logic [31:0] ld_ofs = '0;
  logic [3:0]  ld_size = '0;
  logic        grp_end = 1'b0;
  logic        overlap;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  int     m_cnt = 0;
  int     m_base [4];
  longint m_ofs  [4];
  int     m_size [4];

  always #5 clk = ~clk;

  sld_overlap_detector dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_commit(st_commit), .st_base(st_base), .st_ofs(st_ofs), .st_size(st_size),
    .ld_valid(ld_valid), .ld_base(ld_base), .ld_ofs(ld_ofs), .ld_size(ld_size),
    .grp_end(grp_end), .overlap(overlap)
  );

  function automatic bit model_hit(int b, logic [31:0] o, int s);
    longint lo = longint'($signed(o));
    for (int i = 0; i < m_cnt; i++) begin
      if (m_base[i] == b) begin
        if (m_ofs[i] == lo) return 1'b1;
        if (m_ofs[i] < lo) begin
          if (m_ofs[i] + m_size[i] > lo) return 1'b1;
        end else if (lo + s > m_ofs[i]) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic cyc(bit st, int sb, logic [31:0] so, int ss,
                     bit lv, int lb, logic [31:0] lo, int ls,
                     bit ge, string tag);
    bit exp;
    @(negedge clk);
    st_commit = st; st_base = 8'(sb); st_ofs = so; st_size = 4'(ss);
    ld_valid = lv; ld_base = 8'(lb); ld_ofs = lo; ld_size = 4'(ls);
    grp_end = ge;
    #1;
    exp = lv && model_hit(lb, lo, ls);
    total++;
    if (overlap !== exp) begin
      bad++;
      $display("FAIL %s: overlap actual=%0b expected=%0b", tag, overlap, exp);
    end
    if (ge) m_cnt = 0;
    else if (st && m_cnt < 4) begin
      m_base[m_cnt] = sb; m_ofs[m_cnt] = longint'($signed(so));
      m_size[m_cnt] = ss; m_cnt++;
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    cyc(0,0,0,0, 1,1,32'd100,8, 0, "R1 empty after reset");
    // R2 visibility: query in the commit cycle does not see the store
    cyc(1,1,32'd100,8, 1,1,32'd100,0, 0, "R2 not visible in commit cycle");
    cyc(0,0,0,0, 1,1,32'd100,0, 0, "R2 exact zero-size hit");
    cyc(0,0,0,0, 1,1,32'd107,1, 0, "R3 last byte overlap");
    cyc(0,0,0,0, 1,1,32'd108,4, 0, "R3 adjacent above no hit");
    cyc(0,0,0,0, 1,1,32'd96,4, 0, "R4 adjacent below no hit");
    cyc(0,0,0,0, 1,1,32'd96,5, 0, "R4 one byte reach hit");
    cyc(0,0,0,0, 1,2,32'd100,8, 0, "R5 other base no hit");
    cyc(0,0,0,0, 0,1,32'd100,8, 0, "R9 no query no flag");
    // R6: fill to four, then a dropped fifth
    cyc(1,2,32'd0,4, 0,0,0,0, 0, "R6 fill");
    cyc(1,2,32'd40,4, 0,0,0,0, 0, "R6 fill");
    cyc(1,2,32'd80,4, 0,0,0,0, 0, "R6 fill");
    cyc(1,3,32'd500,8, 0,0,0,0, 0, "R6 fifth store");
    cyc(0,0,0,0, 1,3,32'd500,8, 0, "R6 dropped store no hit");
    cyc(0,0,0,0, 1,2,32'd82,1, 0, "R6 fourth entry hit");
    // R7: group end clears
    cyc(0,0,0,0, 1,1,32'd100,8, 1, "R7 query in clear cycle");
    cyc(0,0,0,0, 1,1,32'd100,8, 0, "R7 cleared no hit");
    // R8: clear wins over commit
    cyc(1,4,32'd10,4, 0,0,0,0, 1, "R8 commit with clear");
    cyc(0,0,0,0, 1,4,32'd10,4, 0, "R8 table empty");
    // R10: signed extremes, no wrap
    cyc(1,5,32'h7FFF_FFFF,15, 0,0,0,0, 0, "R10 store at max");
    cyc(0,0,0,0, 1,5,32'h8000_0000,15, 0, "R10 negative load no hit");
    cyc(0,0,0,0, 1,5,32'h7FFF_FFF0,15, 0, "R10 ends at store no hit");
    cyc(0,0,0,0, 1,5,32'h7FFF_FFF1,15, 0, "R10 wide sum hit");
    cyc(0,0,0,0, 0,0,0,0, 1, "R7 clear");
    cyc(1,5,32'hFFFF_FFFC,8, 0,0,0,0, 0, "R3 negative store");
    cyc(0,0,0,0, 1,5,32'd3,1, 0, "R3 negative store covers 3");
    cyc(0,0,0,0, 1,5,32'd4,1, 0, "R3 negative store ends at 4");
    // random mix covering R2 R3 R4 R5 R6 R7 R8 R9
    for (int n = 0; n < 4000; n++) begin
      cyc(($urandom % 3) == 0, $urandom % 3, 32'($signed(int'($urandom % 41) - 20)),
          $urandom % 16,
          ($urandom % 4) != 0, $urandom % 3, 32'($signed(int'($urandom % 41) - 20)),
          $urandom % 16,
          ($urandom % 9) == 0, "R3/R4 random");
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule